// File: doc/BRIEF.md
# TCP/UDP Header Exception Checker

This block looks at the layer-4 header of one received packet and returns one 4-bit exception code. An upstream parser supplies the inputs for each packet in a single strobed cycle: the protocol (TCP or UDP), how many bytes follow the IP header, the payload length derived from the IP header, the length carried in the L4 header, both port numbers, the TCP flag byte, and a checksum verdict computed elsewhere.

All checks run in parallel. A fixed priority then reduces them to one code, which is registered. The code and a one-cycle done pulse appear on the cycle after the strobe. Header-length, checksum, length-consistency and zero-port problems apply to both protocols. Illegal flag combinations are examined only for TCP.

Top module: `l4_exc_check`

## Requirements
- R1: While reset is asserted (`rst_n` low) and after its release with no strobe, `out_done` is 0 and `out_code` is 0.
- R2: Code 1 is reported when `in_avail_len` is below the minimum header size: 20 bytes for TCP (`in_is_tcp`=1) and 8 bytes for UDP. When this happens, no other condition is examined.
- R3: When the header is long enough and `in_csum_ok` is 0, code 2 is reported.
- R4: When the earlier checks pass and `in_l4_len` differs from `in_ip_len`, code 3 is reported. This applies to UDP always, and to TCP when `TCP_LEN_CHECK`=1 (the default).
- R5: When the earlier checks pass and either `in_src_port` or `in_dst_port` is zero, code 4 is reported.
- R6: For TCP with all earlier checks passing, a flag byte of exactly 0x01 gives code 8, and a flag byte of 0x00 gives code 9. The flag bits are FIN=bit 0, SYN=bit 1, RST=bit 2 and URG=bit 5.
- R7: For TCP with all earlier checks passing, the following combinations are reported regardless of the other flag bits: FIN and RST give code 10, SYN and URG give 11, SYN and RST give 12, SYN and FIN give 13. When several combinations match, the smallest code is reported.
- R8: When several conditions hold at once, the lowest-numbered code among 1 to 4 wins over all others. Flag codes are reported only when none of codes 1 to 4 applies.
- R9: For UDP (`in_is_tcp`=0), the flag byte has no effect, and only codes 0 to 4 can appear.
- R10: `out_done` is 1 exactly in the cycle after a cycle with `in_vld`=1, and `out_code` holds that packet's result in that cycle. When `out_done` is 0, `out_code` is 0. Codes 5, 6, 7 and values above 13 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Packet fields valid this cycle |
| in_is_tcp | input | 1 | 1 = TCP, 0 = UDP |
| in_avail_len | input | LEN_W | Bytes present after the IP header |
| in_ip_len | input | LEN_W | L4 length derived from the IP header |
| in_l4_len | input | LEN_W | Length taken from the L4 header |
| in_src_port | input | PORT_W | Source port |
| in_dst_port | input | PORT_W | Destination port |
| in_tcp_flags | input | FLAG_W | TCP flag byte |
| in_csum_ok | input | 1 | Externally computed checksum passed |
| out_done | output | 1 | Result valid pulse |
| out_code | output | 4 | Exception code |

## Verification
Every result is due exactly one rising edge after its strobe, and the done pulse and the code register share that edge. Because inputs change only on falling edges, the inputs sampled at a rising edge are still on the pins two time units later. The bench therefore compares `out_done` and `out_code` at that moment on every cycle against a behavioural model evaluated on those same inputs. Idle cycles are checked the same way, which confirms that the pulse never lingers and that the code returns to zero.

// File: rtl/l4x_pkg.sv
package l4x_pkg;

   typedef enum logic [3:0] {
      L4X_OK       = 4'd0,
      L4X_SHORT    = 4'd1,
      L4X_CSUM     = 4'd2,
      L4X_LEN      = 4'd3,
      L4X_PORT0    = 4'd4,
      L4X_FIN_ONLY = 4'd8,
      L4X_NO_FLAGS = 4'd9,
      L4X_FIN_RST  = 4'd10,
      L4X_SYN_URG  = 4'd11,
      L4X_SYN_RST  = 4'd12,
      L4X_SYN_FIN  = 4'd13
   } l4x_code_e;

   // flag bit positions inside the TCP flag byte
   localparam int unsigned FLG_FIN = 0;
   localparam int unsigned FLG_SYN = 1;
   localparam int unsigned FLG_RST = 2;
   localparam int unsigned FLG_URG = 5;

   // number of flag rules, evaluated in ascending code order
   localparam int unsigned NRULES = 6;

   typedef struct packed {
      logic       short_hdr;
      logic       csum_bad;
      logic       len_bad;
      logic       port_zero;
      logic       flag_hit;
      logic [3:0] flag_code;
   } l4x_hits_t;

endpackage

// File: rtl/l4x_len_gate.sv
module l4x_len_gate #(
   parameter int unsigned LEN_W         = 16,
   parameter int unsigned TCP_HDR_BYTES = 20,
   parameter int unsigned UDP_HDR_BYTES = 8,
   parameter bit          TCP_LEN_CHECK = 1'b1
) (
   input  logic             is_tcp,
   input  logic [LEN_W-1:0] avail_len,
   input  logic [LEN_W-1:0] ip_len,
   input  logic [LEN_W-1:0] l4_len,
   output logic             short_hdr,
   output logic             len_bad
);
   localparam logic [LEN_W-1:0] TCP_MIN = LEN_W'(TCP_HDR_BYTES);
   localparam logic [LEN_W-1:0] UDP_MIN = LEN_W'(UDP_HDR_BYTES);

   logic [LEN_W-1:0] min_len;
   logic             len_differs;

   assign min_len     = is_tcp ? TCP_MIN : UDP_MIN;
   assign short_hdr   = (avail_len < min_len);
   assign len_differs = (l4_len != ip_len);

   generate
      if (TCP_LEN_CHECK) begin : g_len_both
         assign len_bad = len_differs;
      end else begin : g_len_udp_only
         assign len_bad = len_differs & ~is_tcp;
      end
   endgenerate
endmodule

// File: rtl/l4x_port_zero.sv
module l4x_port_zero #(
   parameter int unsigned PORT_W = 16
) (
   input  logic [PORT_W-1:0] src_port,
   input  logic [PORT_W-1:0] dst_port,
   output logic              port_zero
);
   assign port_zero = (src_port == '0) | (dst_port == '0);
endmodule

// File: rtl/l4x_flag_class.sv
module l4x_flag_class
   import l4x_pkg::*;
#(
   parameter int unsigned FLAG_W = 8
) (
   input  logic              is_tcp,
   input  logic [FLAG_W-1:0] flags,
   output logic              hit,
   output logic [3:0]        code
);
   function automatic logic [FLAG_W-1:0] rule_mask(input int unsigned idx);
      logic [FLAG_W-1:0] m;
      m = '0;
      case (idx)
         0, 1:    m = '1;
         2:       begin m[FLG_FIN] = 1'b1; m[FLG_RST] = 1'b1; end
         3:       begin m[FLG_SYN] = 1'b1; m[FLG_URG] = 1'b1; end
         4:       begin m[FLG_SYN] = 1'b1; m[FLG_RST] = 1'b1; end
         default: begin m[FLG_SYN] = 1'b1; m[FLG_FIN] = 1'b1; end
      endcase
      return m;
   endfunction

   function automatic logic [FLAG_W-1:0] rule_value(input int unsigned idx);
      logic [FLAG_W-1:0] v;
      case (idx)
         0:       begin v = '0; v[FLG_FIN] = 1'b1; end
         1:       v = '0;
         default: v = rule_mask(idx);
      endcase
      return v;
   endfunction

   logic [NRULES-1:0] match;

   generate
      for (genvar gi = 0; gi < NRULES; gi++) begin : g_rule
         localparam logic [FLAG_W-1:0] MASK = rule_mask(gi);
         localparam logic [FLAG_W-1:0] VAL  = rule_value(gi);
         assign match[gi] = is_tcp & ((flags & MASK) == VAL);
      end
   endgenerate

   always_comb begin
      hit  = |match;
      code = 4'd0;
      for (int i = NRULES - 1; i >= 0; i--) begin
         if (match[i]) code = 4'(int'(L4X_FIN_ONLY) + i);
      end
   end
endmodule

// File: rtl/l4x_resolve.sv
module l4x_resolve
   import l4x_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vld,
   input  l4x_hits_t  hits,
   output logic       done,
   output logic [3:0] code
);
   logic [3:0] sel;

   always_comb begin
      if (hits.short_hdr)      sel = L4X_SHORT;
      else if (hits.csum_bad)  sel = L4X_CSUM;
      else if (hits.len_bad)   sel = L4X_LEN;
      else if (hits.port_zero) sel = L4X_PORT0;
      else if (hits.flag_hit)  sel = hits.flag_code;
      else                     sel = L4X_OK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
         code <= 4'd0;
      end else begin
         done <= vld;
         code <= vld ? sel : 4'd0;
      end
   end
endmodule

// File: rtl/l4_exc_check.sv
module l4_exc_check
   import l4x_pkg::*;
#(
   parameter int unsigned LEN_W         = 16,
   parameter int unsigned PORT_W        = 16,
   parameter int unsigned FLAG_W        = 8,
   parameter int unsigned TCP_HDR_BYTES = 20,
   parameter int unsigned UDP_HDR_BYTES = 8,
   parameter bit          TCP_LEN_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic              in_is_tcp,
   input  logic [LEN_W-1:0]  in_avail_len,
   input  logic [LEN_W-1:0]  in_ip_len,
   input  logic [LEN_W-1:0]  in_l4_len,
   input  logic [PORT_W-1:0] in_src_port,
   input  logic [PORT_W-1:0] in_dst_port,
   input  logic [FLAG_W-1:0] in_tcp_flags,
   input  logic              in_csum_ok,
   output logic              out_done,
   output logic [3:0]        out_code
);
   localparam int unsigned LEN_MAX = (1 << LEN_W) - 1;

   generate
      if (FLAG_W < FLG_URG + 1) begin : g_bad_flag_w
         $error("l4_exc_check: FLAG_W too narrow for the URG bit");
      end
      if (TCP_HDR_BYTES > LEN_MAX || UDP_HDR_BYTES > LEN_MAX) begin : g_bad_len_w
         $error("l4_exc_check: LEN_W cannot hold the header minimum");
      end
      if (PORT_W == 0) begin : g_bad_port_w
         $error("l4_exc_check: PORT_W must be nonzero");
      end
   endgenerate

   l4x_hits_t hits;

   l4x_len_gate #(
      .LEN_W(LEN_W), .TCP_HDR_BYTES(TCP_HDR_BYTES),
      .UDP_HDR_BYTES(UDP_HDR_BYTES), .TCP_LEN_CHECK(TCP_LEN_CHECK)
   ) u_len (
      .is_tcp(in_is_tcp), .avail_len(in_avail_len), .ip_len(in_ip_len),
      .l4_len(in_l4_len), .short_hdr(hits.short_hdr), .len_bad(hits.len_bad)
   );

   l4x_port_zero #(.PORT_W(PORT_W)) u_port (
      .src_port(in_src_port), .dst_port(in_dst_port), .port_zero(hits.port_zero)
   );

   l4x_flag_class #(.FLAG_W(FLAG_W)) u_flag (
      .is_tcp(in_is_tcp), .flags(in_tcp_flags),
      .hit(hits.flag_hit), .code(hits.flag_code)
   );

   assign hits.csum_bad = ~in_csum_ok;

   l4x_resolve u_res (
      .clk(clk), .rst_n(rst_n), .vld(in_vld), .hits(hits),
      .done(out_done), .code(out_code)
   );
endmodule

// File: rtl/l4x_chk.sv
module l4x_chk #(
   parameter int unsigned LEN_W         = 16,
   parameter int unsigned PORT_W        = 16,
   parameter int unsigned TCP_HDR_BYTES = 20,
   parameter int unsigned UDP_HDR_BYTES = 8,
   parameter bit          TCP_LEN_CHECK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_vld,
   input logic              in_is_tcp,
   input logic [LEN_W-1:0]  in_avail_len,
   input logic [LEN_W-1:0]  in_ip_len,
   input logic [LEN_W-1:0]  in_l4_len,
   input logic [PORT_W-1:0] in_src_port,
   input logic [PORT_W-1:0] in_dst_port,
   input logic              in_csum_ok,
   input logic              out_done,
   input logic [3:0]        out_code
);
   logic too_short;
   logic len_ok;
   assign too_short = in_is_tcp ? (in_avail_len < LEN_W'(TCP_HDR_BYTES))
                                : (in_avail_len < LEN_W'(UDP_HDR_BYTES));
   assign len_ok = (in_l4_len == in_ip_len) || (in_is_tcp && !TCP_LEN_CHECK);

   p_done_after_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_done);
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_done && out_code == 4'd0));
   p_no_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_code inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15}));
   p_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && too_short) |=> out_code == 4'd1);
   p_csum_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !too_short && !in_csum_ok) |=> out_code == 4'd2);
   p_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !too_short && in_csum_ok && !len_ok) |=> out_code == 4'd3);
   p_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !too_short && in_csum_ok && len_ok &&
       (in_src_port == '0 || in_dst_port == '0)) |=> out_code == 4'd4);
   p_udp_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !in_is_tcp) |=> out_code <= 4'd4);
endmodule

bind l4_exc_check l4x_chk #(
   .LEN_W(LEN_W), .PORT_W(PORT_W), .TCP_HDR_BYTES(TCP_HDR_BYTES),
   .UDP_HDR_BYTES(UDP_HDR_BYTES), .TCP_LEN_CHECK(TCP_LEN_CHECK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_is_tcp(in_is_tcp),
   .in_avail_len(in_avail_len), .in_ip_len(in_ip_len), .in_l4_len(in_l4_len),
   .in_src_port(in_src_port), .in_dst_port(in_dst_port), .in_csum_ok(in_csum_ok),
   .out_done(out_done), .out_code(out_code)
);

// File: tb/sim_l4_exc_check.sv
module sim_l4_exc_check;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic        in_is_tcp = 1'b0;
   logic [15:0] in_avail_len = '0;
   logic [15:0] in_ip_len = '0;
   logic [15:0] in_l4_len = '0;
   logic [15:0] in_src_port = '0;
   logic [15:0] in_dst_port = '0;
   logic [7:0]  in_tcp_flags = '0;
   logic        in_csum_ok = 1'b0;
   logic        out_done;
   logic [3:0]  out_code;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   l4_exc_check u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_is_tcp(in_is_tcp),
      .in_avail_len(in_avail_len), .in_ip_len(in_ip_len), .in_l4_len(in_l4_len),
      .in_src_port(in_src_port), .in_dst_port(in_dst_port),
      .in_tcp_flags(in_tcp_flags), .in_csum_ok(in_csum_ok),
      .out_done(out_done), .out_code(out_code)
   );

   // behavioural model of the requirements
   function automatic int model_code();
      int minlen = in_is_tcp ? 20 : 8;
      if (int'(in_avail_len) < minlen) return 1;
      if (!in_csum_ok) return 2;
      if (in_l4_len != in_ip_len) return 3;
      if (in_src_port == 0 || in_dst_port == 0) return 4;
      if (in_is_tcp) begin
         if (in_tcp_flags == 8'h01) return 8;
         if (in_tcp_flags == 8'h00) return 9;
         if (in_tcp_flags[0] && in_tcp_flags[2]) return 10;
         if (in_tcp_flags[1] && in_tcp_flags[5]) return 11;
         if (in_tcp_flags[1] && in_tcp_flags[2]) return 12;
         if (in_tcp_flags[1] && in_tcp_flags[0]) return 13;
      end
      return 0;
   endfunction

   function automatic string model_req(int c);
      int n = 0;
      int minlen = in_is_tcp ? 20 : 8;
      n += (int'(in_avail_len) < minlen) ? 1 : 0;
      n += (!in_csum_ok) ? 1 : 0;
      n += (in_l4_len != in_ip_len) ? 1 : 0;
      n += (in_src_port == 0 || in_dst_port == 0) ? 1 : 0;
      if (n > 1) return "R8";
      if (!in_is_tcp && in_tcp_flags != 8'h00 && c == 0) return "R9";
      case (c)
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         8, 9: return "R6";
         10, 11, 12, 13: return "R7";
         default: return "R10";
      endcase
   endfunction

   // compare on every clock, 2 time units after the rising edge
   always @(posedge clk) begin
      #2;
      if (!finished) begin
         if (!rst_n) begin
            checks++;
            if (out_done !== 1'b0 || out_code !== 4'd0) begin
               errors++;
               $display("FAIL R1 reset: done=%0b code=%0d expected done=0 code=0",
                        out_done, out_code);
            end
         end else begin
            int exp_c;
            string rq;
            exp_c = in_vld ? model_code() : 0;
            rq = in_vld ? model_req(exp_c) : "R10";
            checks++;
            if (out_done !== in_vld || int'(out_code) != exp_c) begin
               errors++;
               $display("FAIL %s: done=%0b code=%0d expected done=%0b code=%0d",
                        rq, out_done, out_code, in_vld, exp_c);
            end
         end
      end
   end

   task automatic send(input bit tcp, input int avail, input int ipl, input int l4l,
                       input int sp, input int dp, input int fl, input bit ok);
      @(negedge clk);
      in_vld       = 1'b1;
      in_is_tcp    = tcp;
      in_avail_len = 16'(avail);
      in_ip_len    = 16'(ipl);
      in_l4_len    = 16'(l4l);
      in_src_port  = 16'(sp);
      in_dst_port  = 16'(dp);
      in_tcp_flags = 8'(fl);
      in_csum_ok   = ok;
   endtask

   task automatic idle();
      @(negedge clk);
      in_vld       = 1'b0;
      in_tcp_flags = 8'($urandom);
      in_avail_len = 16'($urandom_range(0, 30));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // clean traffic
      send(1, 40, 40, 40, 80, 1234, 8'h10, 1);        // R10 ok TCP
      send(0, 30, 30, 30, 53, 999, 8'h00, 1);         // R9 UDP flags 0 ok
      // header length boundaries (R2)
      send(1, 19, 5, 9, 0, 0, 8'h03, 0);              // R2/R8 short wins all
      send(1, 20, 20, 20, 1, 1, 8'h18, 1);            // boundary passes
      send(0, 7, 7, 7, 1, 1, 8'h00, 1);               // R2 UDP short
      send(0, 8, 8, 8, 1, 1, 8'h00, 1);               // UDP boundary ok
      idle();
      // R3, R4, R5 and their priorities (R8)
      send(1, 50, 50, 51, 0, 7, 8'h01, 0);            // R8 -> 2
      send(0, 50, 50, 49, 0, 7, 8'h00, 1);            // R8 -> 3
      send(1, 50, 50, 50, 0, 7, 8'h00, 1);            // R8 port beats flags -> 4
      send(0, 50, 50, 50, 7, 0, 8'h00, 1);            // R5 dst zero
      send(1, 60, 60, 60, 9, 0, 8'h10, 1);            // R5 dst zero TCP
      // flag codes R6, R7
      send(1, 40, 40, 40, 1, 2, 8'h01, 1);            // R6 -> 8
      send(1, 40, 40, 40, 1, 2, 8'h00, 1);            // R6 -> 9
      send(1, 40, 40, 40, 1, 2, 8'h11, 1);            // FIN+ACK -> 0
      send(1, 40, 40, 40, 1, 2, 8'h05, 1);            // R7 -> 10
      send(1, 40, 40, 40, 1, 2, 8'h15, 1);            // R7 -> 10
      send(1, 40, 40, 40, 1, 2, 8'h22, 1);            // R7 -> 11
      send(1, 40, 40, 40, 1, 2, 8'h06, 1);            // R7 -> 12
      send(1, 40, 40, 40, 1, 2, 8'h03, 1);            // R7 -> 13
      send(1, 40, 40, 40, 1, 2, 8'h07, 1);            // R7 first match -> 10
      send(1, 40, 40, 40, 1, 2, 8'h26, 1);            // R7 first match -> 11
      send(1, 40, 40, 40, 1, 2, 8'hC3, 1);            // R7 -> 13
      // UDP ignores flags (R9)
      send(0, 40, 40, 40, 1, 2, 8'h01, 1);
      send(0, 40, 40, 40, 1, 2, 8'h27, 1);
      idle();
      idle();
      // random traffic with gaps
      for (int n = 0; n < 600; n++) begin
         int base;
         base = $urandom_range(0, 60);
         send($urandom_range(0, 1) == 1,
              ($urandom_range(0, 3) == 0) ? $urandom_range(0, 25) : base + 20,
              base + 20,
              ($urandom_range(0, 5) == 0) ? base + 21 : base + 20,
              ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 65535),
              ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 65535),
              ($urandom_range(0, 1) == 0) ? $urandom_range(0, 7) : $urandom_range(0, 255),
              $urandom_range(0, 5) != 0);
         if ($urandom_range(0, 3) == 0) idle();
      end
      idle();
      idle();
      @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL R10 watchdog: run did not end, actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule